// File: doc/BRIEF.md
# Branch History Shift Accumulator

This block gathers the branch-history field of a program-trace message. Each clock cycle a processor core may report one execution event: a direct or indirect branch that was taken or not taken, a predicated instruction whose condition came out true or false, or a dual-element conditional select that carries separate low and high conditions. Each event becomes one or two history bits. The bits are shifted into a register that starts out holding a single 1. That 1 acts as a stop marker: it shows where the recorded history begins, and it travels with the history when the field is sent.

When a flush is requested, the block presents the register contents and a valid length on the following cycle. The length counts the stop marker. In the same cycle the register is reloaded with the lone marker. When the marker reaches the top bit position the block raises a full flag, and the history must be flushed before it accepts more events. A select event that needs two positions when only one is free flushes the current history by itself, and then both of its bits go into the fresh history.

Top module: `branch_hist_accum`

## Requirements
- R1: While reset is held and on the first cycle after it, `hist_valid_o` and `full_o` are 0. A flush issued before any event then presents word 1 with length 1.
- R2: The register shifts left and each new bit enters at bit 0. For event kind 1 (direct branch), `ev_lo_i` = 1 (taken) shifts in a 1 and `ev_lo_i` = 0 (not taken) shifts in a 0.
- R3: For event kind 2 (indirect branch), taken (`ev_lo_i` = 1) shifts in a 1 and not taken (`ev_lo_i` = 0) shifts in a 0.
- R4: For event kind 3 (predicated instruction), a true condition (`ev_lo_i` = 1) shifts in a 1 and a false condition shifts in a 0.
- R5: Event kind 4 (dual select) shifts in two bits in one cycle. The low condition `ev_lo_i` goes in first and ends at bit 1. The high condition `ev_hi_i` goes in second and ends at bit 0.
- R6: A cycle with `flush_req_i` high produces, one cycle later, a one-cycle `hist_valid_o` pulse. `hist_word_o` then holds the register contents including the stop marker, every bit above the marker is 0, and `hist_len_o` equals the number of recorded bits plus one.
- R7: A flush reloads the register with the lone stop marker. An event that arrives in the same cycle as the flush is recorded in the new history and does not appear in the flushed word.
- R8: `full_o` rises on the cycle after the stop marker reaches bit HIST_W-1. While full and with no flush, events are discarded, `full_o` stays high and no word is presented.
- R9: A kind 4 event that arrives with exactly one free position forces a flush of the current history, presented like R6. The new history then holds the marker followed by the low and high bits, giving a length of 3.
- R10: Cycles with `ev_valid_i` low, or with event kinds 0 and 5 to 7, leave the history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid_i | input | 1 | An event is present this cycle |
| ev_kind_i | input | 3 | Event kind: 1 direct branch, 2 indirect branch, 3 predicated, 4 dual select, others none |
| ev_lo_i | input | 1 | Taken / condition true / low-element condition |
| ev_hi_i | input | 1 | High-element condition (kind 4 only) |
| flush_req_i | input | 1 | Present the history and re-arm |
| hist_valid_o | output | 1 | Flushed history is presented this cycle |
| hist_word_o | output | HIST_W | History bits with the stop marker |
| hist_len_o | output | $clog2(HIST_W+1) | Valid length including the stop marker |
| full_o | output | 1 | Stop marker sits at the top bit |

## Verification
The bench fills the register to exactly one free slot and sends a dual select. A design that split the pair across two histories, or that dropped the pair, would show a wrong flushed length or a new history that is not 0b1LH. It sends an event in the same cycle as a flush, which catches a design that appends the bit to the outgoing word. It drives events while the register is full, which exposes a design that overwrites the stop marker or loses the full flag. It also checks the order of the two select bits, since swapping them gives a word that differs only in bits 1 and 0.

// File: rtl/bha_pkg.sv
package bha_pkg;
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_BR_DIR  = 3'd1,
    EV_BR_IND  = 3'd2,
    EV_PRED    = 3'd3,
    EV_DUAL    = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/bha_event_decode.sv
module bha_event_decode
  import bha_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] kind_i,
  input  logic       lo_i,
  input  logic       hi_i,
  output logic [1:0] nbits_o,
  output logic [1:0] bits_o
);
  ev_kind_e kind_e;

  always_comb begin
    kind_e  = ev_kind_e'(kind_i);
    nbits_o = 2'd0;
    bits_o  = 2'b00;
    if (valid_i) begin
      case (kind_e)
        EV_BR_DIR, EV_BR_IND, EV_PRED: begin
          nbits_o = 2'd1;
          bits_o  = {1'b0, lo_i};
        end
        EV_DUAL: begin
          nbits_o = 2'd2;
          bits_o  = {lo_i, hi_i};
        end
        default: begin
          nbits_o = 2'd0;
          bits_o  = 2'b00;
        end
      endcase
    end
  end
endmodule

// File: rtl/bha_hist_core.sv
module bha_hist_core #(
  parameter int HIST_W = 32,
  parameter int LEN_W  = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        nbits_i,
  input  logic [1:0]        bits_i,
  input  logic              flush_req_i,
  output logic [HIST_W-1:0] hist_q_o,
  output logic [LEN_W-1:0]  len_q_o,
  output logic              fire_o,
  output logic              full_o
);
  localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(HIST_W);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [HIST_W-1:0] STOP_BIT = HIST_W'(1);

  logic [HIST_W-1:0] hist_q, base_h, hist_n;
  logic [LEN_W-1:0]  len_q, base_l, base_free, free, len_n, need;
  logic              force_flush, accept;

  always_comb begin
    free        = LEN_MAX - len_q;
    need        = LEN_W'(nbits_i);
    force_flush = (nbits_i == 2'd2) && (free == LEN_ONE);
    fire_o      = flush_req_i | force_flush;
    base_h      = fire_o ? STOP_BIT : hist_q;
    base_l      = fire_o ? LEN_ONE  : len_q;
    base_free   = LEN_MAX - base_l;
    accept      = (nbits_i != 2'd0) && (base_free >= need);
    hist_n      = base_h;
    len_n       = base_l;
    if (accept) begin
      if (nbits_i == 2'd1) hist_n = (base_h << 1) | HIST_W'(bits_i[0]);
      else                 hist_n = (base_h << 2) | HIST_W'(bits_i);
      len_n = base_l + need;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= STOP_BIT;
      len_q  <= LEN_ONE;
      full_o <= 1'b0;
    end else begin
      hist_q <= hist_n;
      len_q  <= len_n;
      full_o <= (len_n == LEN_MAX);
    end
  end

  assign hist_q_o = hist_q;
  assign len_q_o  = len_q;
endmodule

// File: rtl/bha_out_stage.sv
module bha_out_stage #(
  parameter int HIST_W = 32,
  parameter int LEN_W  = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [HIST_W-1:0] hist_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              valid_o,
  output logic [HIST_W-1:0] word_o,
  output logic [LEN_W-1:0]  len_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      len_o   <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        word_o <= hist_i;
        len_o  <= len_i;
      end
    end
  end
endmodule

// File: rtl/branch_hist_accum.sv
module branch_hist_accum #(
  parameter int HIST_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ev_valid_i,
  input  logic [2:0]                    ev_kind_i,
  input  logic                          ev_lo_i,
  input  logic                          ev_hi_i,
  input  logic                          flush_req_i,
  output logic                          hist_valid_o,
  output logic [HIST_W-1:0]             hist_word_o,
  output logic [$clog2(HIST_W+1)-1:0]   hist_len_o,
  output logic                          full_o
);
  localparam int LEN_W = $clog2(HIST_W + 1);

  logic [1:0]        nbits, bits;
  logic [HIST_W-1:0] hist_q;
  logic [LEN_W-1:0]  len_q;
  logic              fire;

  bha_event_decode u_dec (
    .valid_i (ev_valid_i),
    .kind_i  (ev_kind_i),
    .lo_i    (ev_lo_i),
    .hi_i    (ev_hi_i),
    .nbits_o (nbits),
    .bits_o  (bits)
  );

  bha_hist_core #(.HIST_W(HIST_W), .LEN_W(LEN_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .nbits_i     (nbits),
    .bits_i      (bits),
    .flush_req_i (flush_req_i),
    .hist_q_o    (hist_q),
    .len_q_o     (len_q),
    .fire_o      (fire),
    .full_o      (full_o)
  );

  bha_out_stage #(.HIST_W(HIST_W), .LEN_W(LEN_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .hist_i  (hist_q),
    .len_i   (len_q),
    .valid_o (hist_valid_o),
    .word_o  (hist_word_o),
    .len_o   (hist_len_o)
  );
endmodule

// File: rtl/bha_checker.sv
module bha_checker #(
  parameter int HIST_W = 32,
  parameter int LEN_W  = $clog2(HIST_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid_i,
  input logic [2:0]        ev_kind_i,
  input logic              flush_req_i,
  input logic              hist_valid_o,
  input logic [HIST_W-1:0] hist_word_o,
  input logic [LEN_W-1:0]  hist_len_o,
  input logic              full_o
);
  // R6: a flush request yields a presented word on the next cycle
  p_flush_valid_r6: assert property (@(posedge clk) disable iff (rst)
    flush_req_i |=> hist_valid_o);

  // R6: the stop marker sits at bit len-1 and nothing lies above it
  p_stop_marker_r6: assert property (@(posedge clk) disable iff (rst)
    hist_valid_o |-> (hist_len_o >= LEN_W'(1)) && (hist_len_o <= LEN_W'(HIST_W)) &&
                     ((hist_word_o >> (hist_len_o - LEN_W'(1))) == HIST_W'(1)));

  // R8: full holds and nothing is presented until a flush
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && !flush_req_i) |=> (full_o && !hist_valid_o));

  // R9: a presented word has a cause: a request or a dual select
  p_valid_cause_r9: assert property (@(posedge clk) disable iff (rst)
    hist_valid_o |-> ($past(flush_req_i) || ($past(ev_valid_i) && $past(ev_kind_i) == 3'd4)));

  // R6: the valid pulse lasts one cycle unless flushing again
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (hist_valid_o && !flush_req_i && !(ev_valid_i && ev_kind_i == 3'd4)) |=> !hist_valid_o);
endmodule

bind branch_hist_accum bha_checker #(.HIST_W(HIST_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_valid_i   (ev_valid_i),
  .ev_kind_i    (ev_kind_i),
  .flush_req_i  (flush_req_i),
  .hist_valid_o (hist_valid_o),
  .hist_word_o  (hist_word_o),
  .hist_len_o   (hist_len_o),
  .full_o       (full_o)
);

// File: tb/branch_hist_accum_bench.sv
module branch_hist_accum_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [2:0]    ev_kind = 3'd0;
  logic          ev_lo = 1'b0, ev_hi = 1'b0, flush_req = 1'b0;
  logic          hv, full;
  logic [W-1:0]  word;
  logic [LW-1:0] len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_hist_accum #(.HIST_W(W)) u_branch_hist_accum (
    .clk(clk), .rst(rst), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_lo_i(ev_lo), .ev_hi_i(ev_hi), .flush_req_i(flush_req),
    .hist_valid_o(hv), .hist_word_o(word), .hist_len_o(len), .full_o(full)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs sampled 1 time unit after the edge
  task automatic step(logic v, logic [2:0] k, logic lo, logic hi, logic fl);
    @(negedge clk);
    ev_valid = v; ev_kind = k; ev_lo = lo; ev_hi = hi; flush_req = fl;
    @(posedge clk); #1;
    ev_valid = 0; ev_kind = 0; ev_lo = 0; ev_hi = 0; flush_req = 0;
  endtask

  task automatic flush_expect(string tag, logic [W-1:0] ew, int el);
    step(0, 0, 0, 0, 1);
    chk({tag, " valid"}, 64'(hv), 64'd1);
    chk({tag, " word"}, 64'(word), 64'(ew));
    chk({tag, " len"}, 64'(len), 64'(el));
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", 64'(hv), 64'd0);
    chk("R1 full after reset", 64'(full), 64'd0);
    flush_expect("R1 empty flush", W'(1), 1);
  endtask

  task automatic t_direct();
    step(1, 3'd1, 1, 0, 0);
    step(1, 3'd1, 0, 0, 0);
    step(1, 3'd1, 1, 0, 0);
    flush_expect("R2 direct 1,0,1", W'(4'b1101), 4);
  endtask

  task automatic t_indirect();
    step(1, 3'd2, 0, 0, 0);
    step(1, 3'd2, 1, 0, 0);
    flush_expect("R3 indirect 0,1", W'(3'b101), 3);
  endtask

  task automatic t_pred();
    step(1, 3'd3, 0, 0, 0);
    step(1, 3'd3, 0, 0, 0);
    step(1, 3'd3, 1, 0, 0);
    flush_expect("R4 pred 0,0,1", W'(4'b1001), 4);
  endtask

  task automatic t_dual();
    step(1, 3'd4, 1, 0, 0);
    step(1, 3'd4, 0, 1, 0);
    flush_expect("R5 dual lo1hi0 lo0hi1", W'(5'b11001), 5);
  endtask

  task automatic t_same_cycle();
    step(1, 3'd1, 0, 0, 0);
    step(1, 3'd3, 1, 0, 1);
    chk("R7 same-cycle flushed word", 64'(word), 64'(2'b10));
    chk("R7 same-cycle flushed len", 64'(len), 64'd2);
    flush_expect("R7 event kept in new history", W'(2'b11), 2);
  endtask

  task automatic t_idle();
    step(0, 3'd1, 1, 0, 0);
    step(1, 3'd0, 1, 1, 0);
    step(1, 3'd5, 1, 1, 0);
    step(1, 3'd7, 0, 1, 0);
    chk("R10 no valid from idle", 64'(hv), 64'd0);
    flush_expect("R10 ignored events", W'(1), 1);
  endtask

  task automatic t_full();
    logic [W-1:0] exp = W'(1);
    for (int i = 0; i < W - 1; i++) begin
      step(1, 3'd1, logic'(i % 2), 0, 0);
      exp = (exp << 1) | W'(i % 2);
    end
    chk("R8 full at top", 64'(full), 64'd1);
    step(1, 3'd2, 1, 0, 0);
    step(1, 3'd4, 1, 1, 0);
    chk("R8 full held", 64'(full), 64'd1);
    chk("R8 no word while full", 64'(hv), 64'd0);
    flush_expect("R8 full word", exp, W);
    chk("R8 full cleared", 64'(full), 64'd0);
  endtask

  task automatic t_force();
    logic [W-1:0] exp = W'(1);
    for (int i = 0; i < W - 2; i++) begin
      step(1, 3'd3, logic'((i % 3) == 0), 0, 0);
      exp = (exp << 1) | W'((i % 3) == 0);
    end
    chk("R9 not full with one slot", 64'(full), 64'd0);
    step(1, 3'd4, 1, 0, 0);
    chk("R9 forced valid", 64'(hv), 64'd1);
    chk("R9 forced word", 64'(word), 64'(exp));
    chk("R9 forced len", 64'(len), 64'(W - 1));
    flush_expect("R9 pair in new history", W'(3'b110), 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 64'(hv), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_direct();
    t_indirect();
    t_pred();
    t_dual();
    t_same_cycle();
    t_idle();
    t_full();
    t_force();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule